// File: doc/BRIEF.md
# Power Manager Register Block

This block is the software-visible register file of a power manager. A processor reaches it over a simple 32-bit bus: one request strobe, one write enable, a byte address and write data. Read data is combinational from the address and is valid in the same cycle as a read request. The number of wakeup channels `NUM_WKUP` is a parameter, and the interrupt, wakeup-enable and wake-information layouts all scale with it. The width and reset value of the low-power control word follow the variant that the channel count selects.

Hardware reports to the block on plain inputs. These are one event line per wakeup channel, a fall-through pulse and an abort pulse from the power sequencer, and three fault indications. The block turns enabled wakeup events into interrupt state bits and wake-reason bits. It keeps a lockable wakeup-enable mask and records faults until reset. It drives a single interrupt line and the control bits to the sequencer. The sequencer itself, clock-domain synchronisation and reset distribution live elsewhere.

An address decoder maps the address to an enumerated register select, and every write strobe and the read multiplexer use that select. The decoder has no state and no transitions. The states of the block are the register contents.

Top module: `pwrctl_regs`

## Requirements
- R1: After reset, all of these registers read 0: interrupt state (0x00), interrupt enable (0x04), wakeup enable (0x20), capture disable (0x38), wake info (0x3c) and fault (0x40). The wakeup lock (0x1c) reads 1. The control word (0x14) and `ctrl_o` hold 0x180 with 6 channels, or 0x40 with 4 channels. `irq_o` is 0.
- R2: A write to interrupt state (0x00) clears every bit written as one, after the data is masked to bits [NUM_WKUP-1:0]. A wakeup event on channel i whose wakeup-enable bit i is set sets state bit i. A set arriving in the same cycle as a clear wins.
- R3: A write to interrupt enable (0x04) stores the data masked to [NUM_WKUP-1:0]. A write to interrupt test (0x08) ORs the masked data into the interrupt state. The test address reads 0.
- R4: `irq_o` is high exactly when some interrupt state bit and its enable bit are both set. It follows the registers in the cycle after they are written.
- R5: Bit 0 of the wakeup lock (0x1c) is cleared by writing 0 to it. Writing 1 has no effect, and once cleared the bit stays 0 until reset.
- R6: A write to wakeup enable (0x20) stores the data masked to [NUM_WKUP-1:0] only while the lock bit is 1. While the lock bit is 0, the write is dropped.
- R7: Wake info (0x3c) holds one reason bit per channel in bits [NUM_WKUP-1:0], set by an event on an enabled channel. It holds a fall-through flag at bit NUM_WKUP and an abort flag at bit NUM_WKUP+1, each set by its input pulse. These bits are set only while bit 0 of capture disable (0x38) is 0. The bits stay set until cleared by writing ones, and a set in the same cycle as a clear wins.
- R8: A write to the control word (0x14) keeps only the bits of the variant mask: 0x1F1 with 6 channels, 0x71 with 4 channels. `ctrl_o` shows the stored value.
- R9: Fault (0x40) is read-only, with integrity error at bit 0, escalation timeout at bit 1 and power-domain glitch at bit 2. Each bit is set by a one on its input and stays set until reset. Writes do not change it.
- R10: Reads of unmapped addresses return 0. Writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address |
| wkup_evt_i | input | NUM_WKUP | Per-channel wakeup event |
| fall_through_i | input | 1 | Low-power entry fell through |
| abort_i | input | 1 | Low-power entry aborted |
| fault_intg_i | input | 1 | Register integrity error |
| fault_esc_i | input | 1 | Escalation timeout |
| fault_glitch_i | input | 1 | Main power-domain glitch |
| irq_o | output | 1 | Wakeup interrupt |
| ctrl_o | output | 9 | Stored control word |

## Verification
The hardest case to reach from the ports is a race between hardware and software on the same bit. In that case a wakeup event lands on the same clock edge as a bus write that clears that bit, and the set must survive. The bench reaches it with a task that drives an event pulse and a bus write together for exactly one cycle. It then reads the register back on the following cycle. The locked-enable case is just as hard to reach, because the lock can only be released again by reset. The bench clears the lock late in the run, so that earlier tests can still program the enable mask.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;

    localparam int CTRL_W = 9;

    localparam logic [7:0] OFF_ISTATE = 8'h00;
    localparam logic [7:0] OFF_IEN    = 8'h04;
    localparam logic [7:0] OFF_ITEST  = 8'h08;
    localparam logic [7:0] OFF_CTRL   = 8'h14;
    localparam logic [7:0] OFF_WLOCK  = 8'h1c;
    localparam logic [7:0] OFF_WEN    = 8'h20;
    localparam logic [7:0] OFF_CAPDIS = 8'h38;
    localparam logic [7:0] OFF_WINFO  = 8'h3c;
    localparam logic [7:0] OFF_FAULT  = 8'h40;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_ISTATE,
        SEL_IEN,
        SEL_ITEST,
        SEL_CTRL,
        SEL_WLOCK,
        SEL_WEN,
        SEL_CAPDIS,
        SEL_WINFO,
        SEL_FAULT
    } reg_sel_e;

    // Writable control bits for the variant chosen by the channel count.
    function automatic logic [CTRL_W-1:0] ctrl_mask(input int n);
        return (n == 4) ? 9'h071 : 9'h1f1;
    endfunction

    // Reset value of the control word for that variant.
    function automatic logic [CTRL_W-1:0] ctrl_reset(input int n);
        return (n == 4) ? 9'h040 : 9'h180;
    endfunction

endpackage

// File: rtl/pwrctl_decode.sv
module pwrctl_decode
    import pwrctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);

    always_comb begin
        unique case (addr_i)
            ADDR_W'(OFF_ISTATE): sel_o = SEL_ISTATE;
            ADDR_W'(OFF_IEN):    sel_o = SEL_IEN;
            ADDR_W'(OFF_ITEST):  sel_o = SEL_ITEST;
            ADDR_W'(OFF_CTRL):   sel_o = SEL_CTRL;
            ADDR_W'(OFF_WLOCK):  sel_o = SEL_WLOCK;
            ADDR_W'(OFF_WEN):    sel_o = SEL_WEN;
            ADDR_W'(OFF_CAPDIS): sel_o = SEL_CAPDIS;
            ADDR_W'(OFF_WINFO):  sel_o = SEL_WINFO;
            ADDR_W'(OFF_FAULT):  sel_o = SEL_FAULT;
            default:             sel_o = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/pwrctl_irq.sv
module pwrctl_irq #(
    parameter int NUM_WKUP = 6
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                state_we_i,
    input  logic                enable_we_i,
    input  logic                test_we_i,
    input  logic [NUM_WKUP-1:0] wdata_i,
    input  logic [NUM_WKUP-1:0] evt_set_i,
    output logic [NUM_WKUP-1:0] state_o,
    output logic [NUM_WKUP-1:0] enable_o,
    output logic                irq_o
);

    logic [NUM_WKUP-1:0] state_q, state_d;
    logic [NUM_WKUP-1:0] enable_q;
    logic [NUM_WKUP-1:0] clr_bits, test_bits;

    assign clr_bits  = state_we_i ? wdata_i : '0;
    assign test_bits = test_we_i  ? wdata_i : '0;

    // hardware and test sets take priority over a software clear
    assign state_d = (state_q & ~clr_bits) | test_bits | evt_set_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q  <= '0;
            enable_q <= '0;
        end else begin
            state_q <= state_d;
            if (enable_we_i) enable_q <= wdata_i;
        end
    end

    assign state_o  = state_q;
    assign enable_o = enable_q;
    assign irq_o    = |(state_q & enable_q);

    AST_TEST_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        test_we_i |=> ((state_q & $past(wdata_i)) == $past(wdata_i))); // R3

    AST_STATE_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((state_q & ~$past(state_q) & ~$past(evt_set_i) & ~$past(test_bits)) == '0)); // R2

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_we_i && |(evt_set_i & wdata_i)) |=> ((state_q & $past(evt_set_i)) == $past(evt_set_i))); // R2

endmodule

// File: rtl/pwrctl_wake.sv
module pwrctl_wake #(
    parameter int NUM_WKUP = 6,
    localparam int INFO_W  = NUM_WKUP + 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                lock_we_i,
    input  logic                en_we_i,
    input  logic                capdis_we_i,
    input  logic                info_we_i,
    input  logic [INFO_W-1:0]   wdata_i,
    input  logic [NUM_WKUP-1:0] wkup_evt_i,
    input  logic                fall_through_i,
    input  logic                abort_i,
    output logic                lock_o,
    output logic [NUM_WKUP-1:0] en_o,
    output logic                capdis_o,
    output logic [INFO_W-1:0]   info_o,
    output logic [NUM_WKUP-1:0] evt_set_o
);

    logic                lock_q;
    logic [NUM_WKUP-1:0] en_q;
    logic                capdis_q;
    logic [INFO_W-1:0]   info_q, info_d, info_set, info_clr;

    assign evt_set_o = wkup_evt_i & en_q;
    assign info_set  = capdis_q ? '0 : {abort_i, fall_through_i, evt_set_o};
    assign info_clr  = info_we_i ? wdata_i : '0;
    assign info_d    = (info_q & ~info_clr) | info_set;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lock_q   <= 1'b1;
            en_q     <= '0;
            capdis_q <= 1'b0;
            info_q   <= '0;
        end else begin
            if (lock_we_i && !wdata_i[0]) lock_q <= 1'b0;
            if (en_we_i && lock_q) en_q <= wdata_i[NUM_WKUP-1:0];
            if (capdis_we_i) capdis_q <= wdata_i[0];
            info_q <= info_d;
        end
    end

    assign lock_o   = lock_q;
    assign en_o     = en_q;
    assign capdis_o = capdis_q;
    assign info_o   = info_q;

    AST_EN_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_we_i && !lock_q) |=> $stable(en_q)); // R6

    AST_LOCK_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lock_q |=> !lock_q); // R5

    AST_CAPTURE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        capdis_q |=> ((info_q & ~$past(info_q)) == '0)); // R7

endmodule

// File: rtl/pwrctl_regs.sv
module pwrctl_regs
    import pwrctl_pkg::*;
#(
    parameter int NUM_WKUP = 6,
    parameter int ADDR_W   = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                bus_req_i,
    input  logic                bus_we_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [31:0]         bus_wdata_i,
    output logic [31:0]         bus_rdata_o,
    input  logic [NUM_WKUP-1:0] wkup_evt_i,
    input  logic                fall_through_i,
    input  logic                abort_i,
    input  logic                fault_intg_i,
    input  logic                fault_esc_i,
    input  logic                fault_glitch_i,
    output logic                irq_o,
    output logic [CTRL_W-1:0]   ctrl_o
);

    localparam int INFO_W = NUM_WKUP + 2;
    localparam logic [CTRL_W-1:0] CTRL_MASK = ctrl_mask(NUM_WKUP);
    localparam logic [CTRL_W-1:0] CTRL_RST  = ctrl_reset(NUM_WKUP);

    reg_sel_e            sel;
    logic                wr;
    logic [NUM_WKUP-1:0] istate, ienable, evt_set, wen;
    logic                wlock, capdis;
    logic [INFO_W-1:0]   winfo;
    logic [CTRL_W-1:0]   ctrl_q;
    logic                ctrl_we;
    logic [2:0]          fault_q;
    logic                unused_wdata;

    assign wr           = bus_req_i && bus_we_i;
    assign ctrl_we      = wr && (sel == SEL_CTRL);
    assign unused_wdata = ^bus_wdata_i;

    pwrctl_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (bus_addr_i),
        .sel_o  (sel)
    );

    pwrctl_irq #(.NUM_WKUP(NUM_WKUP)) u_irq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .state_we_i  (wr && (sel == SEL_ISTATE)),
        .enable_we_i (wr && (sel == SEL_IEN)),
        .test_we_i   (wr && (sel == SEL_ITEST)),
        .wdata_i     (bus_wdata_i[NUM_WKUP-1:0]),
        .evt_set_i   (evt_set),
        .state_o     (istate),
        .enable_o    (ienable),
        .irq_o       (irq_o)
    );

    pwrctl_wake #(.NUM_WKUP(NUM_WKUP)) u_wake (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .lock_we_i      (wr && (sel == SEL_WLOCK)),
        .en_we_i        (wr && (sel == SEL_WEN)),
        .capdis_we_i    (wr && (sel == SEL_CAPDIS)),
        .info_we_i      (wr && (sel == SEL_WINFO)),
        .wdata_i        (bus_wdata_i[INFO_W-1:0]),
        .wkup_evt_i     (wkup_evt_i),
        .fall_through_i (fall_through_i),
        .abort_i        (abort_i),
        .lock_o         (wlock),
        .en_o           (wen),
        .capdis_o       (capdis),
        .info_o         (winfo),
        .evt_set_o      (evt_set)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q  <= CTRL_RST;
            fault_q <= '0;
        end else begin
            if (ctrl_we) ctrl_q <= bus_wdata_i[CTRL_W-1:0] & CTRL_MASK;
            fault_q <= fault_q | {fault_glitch_i, fault_esc_i, fault_intg_i};
        end
    end

    assign ctrl_o = ctrl_q;

    always_comb begin
        unique case (sel)
            SEL_ISTATE: bus_rdata_o = 32'(istate);
            SEL_IEN:    bus_rdata_o = 32'(ienable);
            SEL_CTRL:   bus_rdata_o = 32'(ctrl_q);
            SEL_WLOCK:  bus_rdata_o = 32'(wlock);
            SEL_WEN:    bus_rdata_o = 32'(wen);
            SEL_CAPDIS: bus_rdata_o = 32'(capdis);
            SEL_WINFO:  bus_rdata_o = 32'(winfo);
            SEL_FAULT:  bus_rdata_o = 32'(fault_q);
            default:    bus_rdata_o = '0;
        endcase
    end

    AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((fault_q & $past(fault_q)) == $past(fault_q))); // R9

    AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_we |=> $stable(ctrl_q)); // R8

endmodule

// File: tb/sim_pwrctl_regs.sv
module sim_pwrctl_regs;

    localparam int PERIOD = 10;
    localparam int N = 6;
    localparam logic [31:0] WMASK = 32'h3f;
    localparam logic [31:0] CMASK = 32'h1f1;
    localparam logic [31:0] CRST  = 32'h180;

    logic        clk = 0, rst_ni = 0;
    logic        req = 0, we = 0;
    logic [7:0]  addr = 0;
    logic [31:0] wdata = 0, rdata;
    logic [N-1:0] evt = 0;
    logic        ft = 0, ab = 0, f_intg = 0, f_esc = 0, f_gl = 0;
    logic        irq;
    logic [8:0]  ctrl;

    int vectors = 0, fails = 0;
    bit done = 0;

    pwrctl_regs u0 (
        .clk_i(clk), .rst_ni(rst_ni), .bus_req_i(req), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .wkup_evt_i(evt), .fall_through_i(ft), .abort_i(ab),
        .fault_intg_i(f_intg), .fault_esc_i(f_esc), .fault_glitch_i(f_gl),
        .irq_o(irq), .ctrl_o(ctrl)
    );

    always #(PERIOD/2) clk = ~clk;

    // behavioural reference
    logic [31:0] m_state, m_en, m_wen, m_lock, m_cap, m_info, m_ctrl, m_fault;
    logic [31:0] ev, nst, ninf;

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h00: return m_state;
            8'h04: return m_en;
            8'h14: return m_ctrl;
            8'h1c: return m_lock;
            8'h20: return m_wen;
            8'h38: return m_cap;
            8'h3c: return m_info;
            8'h40: return m_fault;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_ni) begin
            m_state = 0; m_en = 0; m_wen = 0; m_lock = 1; m_cap = 0;
            m_info = 0; m_ctrl = CRST; m_fault = 0;
        end else begin
            ev  = {26'b0, evt} & m_wen;
            nst = m_state;
            if (req && we && addr == 8'h00) nst = nst & ~(wdata & WMASK);
            if (req && we && addr == 8'h08) nst = nst | (wdata & WMASK);
            nst = nst | ev;
            ninf = m_info;
            if (req && we && addr == 8'h3c) ninf = ninf & ~(wdata & 32'hff);
            if (m_cap[0] == 1'b0) ninf = ninf | ev | {24'b0, ab, ft, 6'b0};
            if (req && we && addr == 8'h04) m_en = wdata & WMASK;
            if (req && we && addr == 8'h14) m_ctrl = wdata & CMASK;
            if (req && we && addr == 8'h20 && m_lock[0]) m_wen = wdata & WMASK;
            if (req && we && addr == 8'h38) m_cap = wdata & 32'h1;
            if (req && we && addr == 8'h1c && !wdata[0]) m_lock = 0;
            m_fault = m_fault | {29'b0, f_gl, f_esc, f_intg};
            m_state = nst;
            m_info = ninf;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_ni && !done) begin
            check("R4 model irq", {31'b0, irq}, {31'b0, |(m_state & m_en)});
            check("R8 model ctrl", {23'b0, ctrl}, m_ctrl);
            if (req && !we) check("R10 model read", rdata, exp_rd(addr));
        end
    end

    // all tasks start and end just after a rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        req = 1; we = 1; addr = a; wdata = d;
        @(posedge clk); #1;
        req = 0; we = 0;
    endtask

    task automatic wr_evt(input logic [7:0] a, input logic [31:0] d, input logic [N-1:0] e);
        req = 1; we = 1; addr = a; wdata = d; evt = e;
        @(posedge clk); #1;
        req = 0; we = 0; evt = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        req = 1; we = 0; addr = a;
        @(negedge clk);
        check(tag, rdata, exp);
        @(posedge clk); #1;
        req = 0;
    endtask

    task automatic pulse(input logic [N-1:0] e, input logic f, input logic b);
        evt = e; ft = f; ab = b;
        @(posedge clk); #1;
        evt = 0; ft = 0; ab = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_ni = 1;
        @(posedge clk); #1;

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 ctrl_o", {23'b0, ctrl}, CRST);
        rd(8'h00, 32'h0, "R1 istate");
        rd(8'h04, 32'h0, "R1 ienable");
        rd(8'h14, CRST, "R1 control");
        rd(8'h1c, 32'h1, "R1 lock");
        rd(8'h20, 32'h0, "R1 wen");
        rd(8'h38, 32'h0, "R1 capdis");
        rd(8'h3c, 32'h0, "R1 winfo");
        rd(8'h40, 32'h0, "R1 fault");

        // R8 control mask
        wr(8'h14, 32'hffff_ffff);
        rd(8'h14, 32'h1f1, "R8 masked");
        check("R8 ctrl_o", {23'b0, ctrl}, 32'h1f1);
        wr(8'h14, 32'h0000_0010);
        rd(8'h14, 32'h10, "R8 single bit");

        // R3 enable / test, R4 irq, R2 clear
        wr(8'h04, 32'hffff_ffff);
        rd(8'h04, 32'h3f, "R3 enable masked");
        wr(8'h08, 32'hffc0_0005);
        rd(8'h00, 32'h05, "R3 test sets");
        rd(8'h08, 32'h0, "R3 test reads zero");
        check("R4 irq high", {31'b0, irq}, 32'h1);
        wr(8'h00, 32'h0000_0001);
        rd(8'h00, 32'h04, "R2 w1c");
        wr(8'h04, 32'h0000_0001);
        check("R4 irq low", {31'b0, irq}, 32'h0);
        wr(8'h00, 32'hffff_ffff);
        rd(8'h00, 32'h0, "R2 clear all");

        // R6 enable writable, R7 / R2 capture
        wr(8'h20, 32'h0000_004a);
        rd(8'h20, 32'h0a, "R6 wen stored");
        pulse(6'h0f, 0, 0);
        rd(8'h3c, 32'h0a, "R7 reasons");
        rd(8'h00, 32'h0a, "R2 event sets state");
        pulse(6'h00, 1, 0);
        rd(8'h3c, 32'h4a, "R7 fall-through");
        pulse(6'h00, 0, 1);
        rd(8'h3c, 32'hca, "R7 abort");
        wr(8'h3c, 32'h0000_0002);
        rd(8'h3c, 32'hc8, "R7 w1c");
        wr_evt(8'h3c, 32'h0000_0008, 6'h08);
        rd(8'h3c, 32'hc8, "R7 set beats clear");
        wr_evt(8'h00, 32'h0000_0008, 6'h08);
        rd(8'h00, 32'h0a, "R2 set beats clear");

        // R7 capture disabled
        wr(8'h3c, 32'hffff_ffff);
        wr(8'h38, 32'h1);
        pulse(6'h02, 1, 1);
        rd(8'h3c, 32'h0, "R7 capture disabled");
        wr(8'h38, 32'h0);
        pulse(6'h02, 0, 0);
        rd(8'h3c, 32'h02, "R7 capture re-enabled");

        // R5 / R6 lock
        wr(8'h1c, 32'h1);
        rd(8'h1c, 32'h1, "R5 write one no effect");
        wr(8'h1c, 32'h0);
        rd(8'h1c, 32'h0, "R5 cleared");
        wr(8'h20, 32'h3f);
        rd(8'h20, 32'h0a, "R6 write dropped");
        wr(8'h1c, 32'h1);
        rd(8'h1c, 32'h0, "R5 stays cleared");

        // R9 fault
        f_esc = 1; @(posedge clk); #1; f_esc = 0;
        rd(8'h40, 32'h2, "R9 esc");
        wr(8'h40, 32'h0);
        rd(8'h40, 32'h2, "R9 write ignored");
        f_intg = 1; f_gl = 1; @(posedge clk); #1; f_intg = 0; f_gl = 0;
        rd(8'h40, 32'h7, "R9 all");

        // R10 unmapped
        wr(8'h0c, 32'hffff_ffff);
        wr(8'h44, 32'hffff_ffff);
        rd(8'h0c, 32'h0, "R10 unmapped 0c");
        rd(8'h44, 32'h0, "R10 unmapped 44");
        rd(8'h14, 32'h10, "R10 control untouched");

        repeat (2) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule